// File: doc/BRIEF.md
# Serial Diagnostic and Timing-Configuration Port

This block is the serial slave side of a multi-channel driver. Each channel reports faults on a one-cycle input; the block keeps them as sticky bits in a failure register. When the host pulls chip-select low, the failure register is copied into an 8-bit shift register. Its most significant bit is driven on the serial output before any serial clock edge, and the remaining bits follow MSB first. A new configuration byte is received on the serial input during the same eight clocks. The failure register is emptied on the first rising serial clock of the frame, so each fault is reported once.

When chip-select returns high after exactly eight serial clocks, the received byte is split into two codes and turned into microsecond counts. A 3-bit field gives a base interval on a 192 µs offset with a 32 µs step. A 5-bit field gives a secondary interval with a 2 µs step. All three pins are sampled by the system clock through two-flop synchronizers, and edges are detected there. The system clock must therefore run at least four times as fast as the serial clock.

Top module: `dsr_diag_port`

## Requirements
- R1: After reset the base interval output is 192, the secondary interval output is 0, the serial output enable is low, and the failure register holds zero, so the first frame shifts out 8'h00.
- R2: While chip-select is high, the serial output enable is 0 and the serial output is driven 0.
- R3: After chip-select falls, the enable goes high and the serial output shows bit 7 of the failure register before any serial clock edge.
- R4: The first rising serial clock edge of a frame keeps bit 7 on the output. Rising edges 2 to 8 move the output to bits 6 down to 0 in turn, so a host sampling on falling edges reads the register MSB first.
- R5: The serial input is sampled on each falling serial clock edge. The first bit sampled becomes bit 7 of the received byte.
- R6: The base interval output equals 192 + 32 × byte[2:0], giving 192 to 416.
- R7: The secondary interval output equals 2 × byte[7:3], giving 0 to 62.
- R8: The received byte is applied on the rising chip-select only if exactly 8 falling serial clock edges occurred in the frame. With any other count, both interval outputs keep their previous values.
- R9: A high level on fault input i for one system cycle sets failure bit i. Bits stay set and accumulate until cleared.
- R10: The failure register is cleared on the first rising serial clock edge of each frame. A fault reported in one frame does not appear in the next unless it recurs.
- R11: A fault that arrives in the same system cycle as the clear stays set and is reported in the following frame.
- R12: Each pin passes two synchronizer flops and one edge stage. The enable rises on the third system clock edge after chip-select falls, not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4× the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csn_pin_i | input | 1 | Chip-select pin, active low |
| sck_pin_i | input | 1 | Serial clock pin, idle low |
| sdi_pin_i | input | 1 | Serial data in |
| fault_i | input | 8 | Per-channel fault pulses, bit i for channel i |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data out |
| t1_us_o | output | 10 | Base interval in microseconds |
| t2_us_o | output | 10 | Secondary interval in microseconds |

## Verification
The bench targets the edges of a frame.

- **Bit timing.** Bit 7 must already be on the line before the first rising edge and must stay there through that edge. A design that shifts on every rising edge loses the top bit and reads back one position off.
- **Clock count.** Frames of seven and nine clocks must leave the intervals untouched. A design that decodes at any chip-select release corrupts the timing with a partial byte.
- **Fault at the clear.** A fault is injected in exactly the cycle of the clear. A design that clears after merging new faults drops that fault silently.
- **Enable latency.** The enable is probed one cycle early and on time, which catches a synchronizer stage that was left out.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int DSR_T1_W      = 3;
  localparam int DSR_T2_W      = 5;
  localparam int DSR_T1_BASE   = 192;
  localparam int DSR_T1_STEP   = 32;
  localparam int DSR_T2_STEP   = 2;
  localparam int DSR_TIME_W    = 10;

  typedef enum int {
    PIN_CSN = 0,
    PIN_SCK = 1,
    PIN_SDI = 2
  } pin_idx_e;
  localparam int DSR_NPIN = 3;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } spi_evt_t;
endpackage

// File: rtl/dsr_pin_sync.sv
module dsr_pin_sync #(
  parameter int          N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= RST_VAL[g];
        lvl_q[g]  <= RST_VAL[g];
      end else begin
        meta_q[g] <= pin_i[g];
        lvl_q[g]  <= meta_q[g];
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/dsr_fail_reg.sv
module dsr_fail_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] fault_i,
  output logic [W-1:0] fail_o
);
  logic [W-1:0] fail_q, fail_d;

  always_comb begin
    fail_d = clr_i ? '0 : fail_q;
    fail_d = fail_d | fault_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= '0;
    else         fail_q <= fail_d;
  end

  assign fail_o = fail_q;

  // R9: bits already set survive any cycle without a clear
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((fail_q & $past(fail_q)) == $past(fail_q)));
  // R10: after a clear only the faults of that cycle remain
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((fail_q & ~$past(fault_i)) == '0));
  // R11: a fault is never lost, clear or not
  p_fault_kept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i != '0) |=> ((fail_q & $past(fault_i)) == $past(fault_i)));
endmodule

// File: rtl/dsr_shift_engine.sv
module dsr_shift_engine #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         sdi_i,
  input  logic [W-1:0] par_i,
  output logic         sdo_o,
  output logic         clr_o,
  output logic [W-1:0] word_o,
  output logic         full_o
);
  localparam int CNT_MAX = W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [W-1:0]     sh_q, sh_d;
  logic             sdo_q, sdo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             first_q, first_d;

  always_comb begin
    sh_d    = sh_q;
    sdo_d   = sdo_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    if (load_i) begin
      sh_d    = par_i;
      sdo_d   = par_i[W-1];
      cnt_d   = '0;
      first_d = 1'b1;
    end else begin
      if (rise_i) begin
        sdo_d   = sh_q[W-1];
        first_d = 1'b0;
      end
      if (fall_i) begin
        sh_d = {sh_q[W-2:0], sdi_i};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      sdo_q   <= 1'b0;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      sdo_q   <= sdo_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
    end
  end

  assign sdo_o  = sdo_q;
  assign clr_o  = rise_i & first_q & ~load_i;
  assign word_o = sh_q;
  assign full_o = (cnt_q == CNT_W'(W));

  // R4: output bit moves only on a load or a rising serial edge
  p_sdo_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i || rise_i) |=> $stable(sdo_q));
  // R5: a falling edge brings the sampled input into the low bit
  p_rx_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !load_i) |=> (sh_q[0] == $past(sdi_i)));
  // R8: every frame starts its edge count from zero
  p_cnt_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0));
endmodule

// File: rtl/dsr_time_dec.sv
module dsr_time_dec #(
  parameter int T1_W    = 3,
  parameter int T2_W    = 5,
  parameter int T1_BASE = 192,
  parameter int T1_STEP = 32,
  parameter int T2_STEP = 2,
  parameter int TIME_W  = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 apply_i,
  input  logic [T1_W+T2_W-1:0] word_i,
  output logic [TIME_W-1:0]    t1_us_o,
  output logic [TIME_W-1:0]    t2_us_o
);
  localparam int T1_MAX = T1_BASE + T1_STEP * ((1 << T1_W) - 1);

  logic [T1_W-1:0] t1c_q, t1c_d;
  logic [T2_W-1:0] t2c_q, t2c_d;

  always_comb begin
    t1c_d = t1c_q;
    t2c_d = t2c_q;
    if (apply_i) begin
      t1c_d = word_i[T1_W-1:0];
      t2c_d = word_i[T1_W+T2_W-1:T1_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1c_q <= '0;
      t2c_q <= '0;
    end else begin
      t1c_q <= t1c_d;
      t2c_q <= t2c_d;
    end
  end

  always_comb begin
    t1_us_o = TIME_W'(T1_BASE) + TIME_W'(T1_STEP) * TIME_W'(t1c_q);
    t2_us_o = TIME_W'(T2_STEP) * TIME_W'(t2c_q);
  end

  // R8: stored codes change only on an accepted frame
  p_code_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> ($stable(t1c_q) && $stable(t2c_q)));
  // R6: base interval stays in its legal span
  p_t1_span_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(t1_us_o) >= T1_BASE) && (int'(t1_us_o) <= T1_MAX));
endmodule

// File: rtl/dsr_diag_port.sv
module dsr_diag_port
  import dsr_pkg::*;
#(
  parameter int T1_W    = DSR_T1_W,
  parameter int T2_W    = DSR_T2_W,
  parameter int T1_BASE = DSR_T1_BASE,
  parameter int T1_STEP = DSR_T1_STEP,
  parameter int T2_STEP = DSR_T2_STEP,
  parameter int TIME_W  = DSR_TIME_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   csn_pin_i,
  input  logic                   sck_pin_i,
  input  logic                   sdi_pin_i,
  input  logic [T1_W+T2_W-1:0]   fault_i,
  output logic                   sdo_o,
  output logic                   sdo_oe_o,
  output logic [TIME_W-1:0]      t1_us_o,
  output logic [TIME_W-1:0]      t2_us_o
);
  localparam int W = T1_W + T2_W;
  localparam logic [DSR_NPIN-1:0] PIN_IDLE = 3'b001;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic [DSR_NPIN-1:0] pins, lvl;
  assign pins = {sdi_pin_i, sck_pin_i, csn_pin_i};

  dsr_pin_sync #(.N(DSR_NPIN), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .pin_i  (pins),
    .lvl_o  (lvl)
  );

  logic csn_prv_q, csn_prv_d, sck_prv_q, sck_prv_d;
  always_comb begin
    csn_prv_d = lvl[PIN_CSN];
    sck_prv_d = lvl[PIN_SCK];
  end
  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      csn_prv_q <= 1'b1;
      sck_prv_q <= 1'b0;
    end else begin
      csn_prv_q <= csn_prv_d;
      sck_prv_q <= sck_prv_d;
    end
  end

  spi_evt_t evt;
  logic     in_frame;
  always_comb begin
    in_frame  = ~csn_prv_q & ~lvl[PIN_CSN];
    evt.start = csn_prv_q & ~lvl[PIN_CSN];
    evt.stop  = ~csn_prv_q & lvl[PIN_CSN];
    evt.rise  = in_frame & lvl[PIN_SCK] & ~sck_prv_q;
    evt.fall  = in_frame & ~lvl[PIN_SCK] & sck_prv_q;
  end

  logic [W-1:0] fail_word, rx_word;
  logic         clr, full, sdo_bit;

  dsr_fail_reg #(.W(W)) u_fail (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_q),
    .clr_i   (clr),
    .fault_i (fault_i),
    .fail_o  (fail_word)
  );

  dsr_shift_engine #(.W(W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .load_i (evt.start),
    .rise_i (evt.rise),
    .fall_i (evt.fall),
    .sdi_i  (lvl[PIN_SDI]),
    .par_i  (fail_word),
    .sdo_o  (sdo_bit),
    .clr_o  (clr),
    .word_o (rx_word),
    .full_o (full)
  );

  dsr_time_dec #(
    .T1_W(T1_W), .T2_W(T2_W), .T1_BASE(T1_BASE),
    .T1_STEP(T1_STEP), .T2_STEP(T2_STEP), .TIME_W(TIME_W)
  ) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_q),
    .apply_i (evt.stop & full),
    .word_i  (rx_word),
    .t1_us_o (t1_us_o),
    .t2_us_o (t2_us_o)
  );

  assign sdo_oe_o = ~csn_prv_q;
  assign sdo_o    = sdo_oe_o & sdo_bit;

  // R3: frame start puts the top failure bit on an enabled output
  p_sdo_start_r3: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    evt.start |=> (sdo_oe_o && (sdo_o == $past(fail_word[W-1]))));
  // R8: a release with a wrong clock count leaves the intervals alone
  p_short_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (evt.stop && !full) |=> ($stable(t1_us_o) && $stable(t2_us_o)));
  // R10: the clear strobe only fires inside a frame
  p_clr_in_frame_r10: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    clr |-> in_frame);
endmodule

// File: tb/dsr_diag_port_tb.sv
module dsr_diag_port_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csn = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [7:0] fault = 8'h00;
  logic       sdo, sdo_oe;
  logic [9:0] t1_us, t2_us;

  always #4 clk = ~clk;

  dsr_diag_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csn_pin_i(csn), .sck_pin_i(sck),
    .sdi_pin_i(sdi), .fault_i(fault), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .t1_us_o(t1_us), .t2_us_o(t2_us));

  int total = 0, bad = 0;
  int cyc = 0, last_chg = 0;
  bit live = 0, finished = 0;

  // reference model state
  logic [7:0] fail_m = 8'h00, out_m = 8'h00, rx_m = 8'h00;
  int t1c = 0, t2c = 0, rcnt = 0, fcnt = 0;
  logic exp_oe = 1'b0, exp_sdo = 1'b0;
  bit sdo_known = 1;
  string sdo_tag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison once the pins have settled through the synchronizers
  always @(negedge clk) begin
    if (live && !finished && (cyc - last_chg) >= 4) begin
      chk(csn ? "R2" : "R3", int'(sdo_oe), int'(exp_oe));
      if (sdo_known) chk(sdo_tag, int'(sdo), int'(exp_sdo));
      chk("R6", int'(t1_us), 192 + 32 * t1c);
      chk("R7", int'(t2_us), 2 * t2c);
    end
  end

  task automatic cs_low();
    @(negedge clk);
    csn = 1'b0; last_chg = cyc;
    out_m = fail_m; rx_m = 8'h00; rcnt = 0; fcnt = 0;
    exp_oe = 1'b1; exp_sdo = out_m[7]; sdo_known = 1; sdo_tag = "R3";
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R12", int'(sdo_oe), 0);
    @(posedge clk); @(negedge clk);
    chk("R12", int'(sdo_oe), 1);
    chk("R3", int'(sdo), int'(out_m[7]));
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, input logic [7:0] inj, inout logic [7:0] rd);
    @(negedge clk);
    sdi = b; sck = 1'b1; last_chg = cyc;
    rcnt++;
    sdo_tag = "R4";
    if (rcnt == 1) fail_m = 8'h00;
    if (rcnt >= 2 && rcnt <= 8) exp_sdo = out_m[8 - rcnt];
    else if (rcnt > 8) sdo_known = 0;
    if (inj != 8'h00) begin
      // two synchronizer edges, then the edge that acts: fault lands with the clear
      @(posedge clk); @(posedge clk); @(negedge clk);
      fault = inj;
      @(posedge clk); @(negedge clk);
      fault = 8'h00;
      fail_m = inj;
      repeat (HALF - 2) @(negedge clk);
    end else begin
      repeat (HALF) @(negedge clk);
    end
    rd = {rd[6:0], sdo};
    sck = 1'b0; last_chg = cyc;
    fcnt++;
    rx_m = {rx_m[6:0], b};
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk);
    csn = 1'b1; last_chg = cyc;
    if (fcnt == 8) begin
      t1c = int'(rx_m[2:0]);
      t2c = int'(rx_m[7:3]);
    end
    exp_oe = 1'b0; exp_sdo = 1'b0; sdo_known = 1; sdo_tag = "R2";
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] w, input int nb, input logic [7:0] inj,
                       output logic [7:0] rd);
    logic [7:0] acc = 8'h00;
    cs_low();
    for (int i = 0; i < nb; i++) begin
      clk_bit((i < 8) ? w[7 - i] : 1'b0, (i == 0) ? inj : 8'h00, acc);
    end
    cs_high();
    rd = acc;
  endtask

  task automatic pulse_fault(input logic [7:0] m);
    @(negedge clk); fault = m;
    @(negedge clk); fault = 8'h00;
    fail_m = fail_m | m;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cyc < 150000 && !finished) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] rd;
    logic [7:0] words [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3A};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    // R1: reset state
    chk("R1", int'(t1_us), 192);
    chk("R1", int'(t2_us), 0);
    chk("R1", int'(sdo_oe), 0);
    chk("R2", int'(sdo), 0);
    live = 1;

    frame(8'h5C, 8, 8'h00, rd);
    chk("R1", int'(rd), 0);
    // R5: received byte rebuilt from both outputs
    chk("R5", ((int'(t2_us) / 2) << 3) | ((int'(t1_us) - 192) / 32), 8'h5C);

    foreach (words[k]) begin
      frame(words[k], 8, 8'h00, rd);
      chk("R6", int'(t1_us), 192 + 32 * int'(words[k][2:0]));
      chk("R7", int'(t2_us), 2 * int'(words[k][7:3]));
    end

    // R8: wrong clock counts change nothing
    frame(8'h11, 7, 8'h00, rd);
    chk("R8", int'(t1_us), 192 + 32 * 2);
    chk("R8", int'(t2_us), 2 * 7);
    frame(8'h11, 9, 8'h00, rd);
    chk("R8", int'(t1_us), 192 + 32 * 2);
    chk("R8", int'(t2_us), 2 * 7);

    // R9: sticky and accumulating faults, read MSB first (R4)
    pulse_fault(8'h81);
    pulse_fault(8'h04);
    frame(8'h00, 8, 8'h00, rd);
    chk("R9", int'(rd), 8'h85);
    chk("R4", int'(rd[7]), 1);
    // R10: cleared by the previous frame
    frame(8'h00, 8, 8'h00, rd);
    chk("R10", int'(rd), 0);

    // R11: fault coinciding with the clear survives
    pulse_fault(8'h60);
    frame(8'h09, 8, 8'h12, rd);
    chk("R9", int'(rd), 8'h60);
    frame(8'h09, 8, 8'h00, rd);
    chk("R11", int'(rd), 8'h12);
    frame(8'h09, 8, 8'h00, rd);
    chk("R10", int'(rd), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule